// File: doc/BRIEF.md
# Rollover-Locked Serial Frame Transmitter

This block sends one asynchronous serial frame for each byte it accepts. The frame has a low start bit, then eight data bits with the least significant bit first, then a high stop bit. Bit timing comes from a free-running divide-by-16 counter. The counter advances on an oversampling tick that arrives at sixteen times the baud rate, and that tick is supplied from outside. A frame is not launched at the moment of the write. It waits for the next rollover of the divider, so every bit edge falls on a divider boundary. The rollover pulse is also brought out so that a receiver can share the same divider.

The byte is loaded into a nine-bit shift register with a 1 marker above the most significant bit. Bits leave to the right while zeros fill from the left. When the marker sits one place above the output and everything above it is zero, the controller performs one last shift, ends the frame and raises a completion flag. The flag stays up until it is cleared explicitly. A write that arrives while a frame is waiting or on the line is dropped.

Top module: `bsync_uart_tx`

## Requirements
- R1: The line carries, in order: start bit 0, data bits 0 to 7 of the written byte (LSB first), then level 1 for the stop bit.
- R2: Each start and data bit occupies exactly the interval between two consecutive divider rollovers, that is 16 oversampling ticks, whatever the spacing of those ticks.
- R3: After an accepted write the line stays at 1 until the first rollover taken strictly after the write cycle. The start bit appears in the cycle after that rollover.
- R4: The completion flag rises in the cycle after the 10th rollover that follows the accepted write. At that edge the line returns to 1.
- R5: A write strobe while a frame is pending or in progress is ignored: the frame on the line is unchanged and no extra frame follows.
- R6: The completion flag holds at 1 until the clear input is high at a clock edge. If completion and clear coincide, completion wins.
- R7: In reset and directly after it, the line is 1, the flag is 0 and the divider count is 0.
- R8: The rollover output is high exactly when the oversampling tick is high and the divider count is 15. The divider runs continuously whether a frame is active or not.
- R9: A write is accepted in the very cycle after the frame ends, so frames may be sent back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| os_tick | input | 1 | Oversampling tick at 16x baud, one cycle wide |
| wr_en | input | 1 | Write strobe for the byte |
| wr_byte | input | 8 | Byte to transmit |
| done_clr | input | 1 | Clears the completion flag |
| txd | output | 1 | Serial line, idles at 1 |
| done_flag | output | 1 | Completion flag |
| bit_roll | output | 1 | Divider rollover pulse for the receive side |

## Verification
Each fault in the shift register or the marker test shows on the line as a wrong data bit, or as a stop bit that comes early or late. The per-cycle comparison therefore catches it within one bit time, which is 16 ticks. A divider fault moves the rollover pulse in the same cycle and shifts every bit edge after it. A controller that starts on the write, or that accepts a second write, shows up within one bit time as an early start bit or a changed frame. A flag error is visible one cycle after the tenth rollover.

// File: rtl/bsync_uart_tx_pkg.sv
package bsync_uart_tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_START = 2'd2,
    ST_BITS  = 2'd3
  } tx_state_e;

  // level on the serial line for the current phase
  function automatic logic line_level(input logic frame_on, input logic data_on,
                                      input logic sh_lsb);
    if (!frame_on) return 1'b1;
    if (!data_on)  return 1'b0;
    return sh_lsb;
  endfunction
endpackage

// File: rtl/bsync_uart_tx_div.sv
module bsync_uart_tx_div #(
  parameter int DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic roll
);
  localparam int CNT_W = $clog2(DIV);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q;

  assign roll = tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (roll) cnt_q <= '0;
    else if (tick) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/bsync_uart_tx_shreg.sv
module bsync_uart_tx_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              shift,
  output logic [DATA_W:0]   sh,
  output logic              final_pos
);
  localparam int SH_W = DATA_W + 1;

  // marker one place above the output, all higher positions clear
  function automatic logic marker_at_end(input logic [SH_W-1:0] v);
    return v[1] && (v[SH_W-1:2] == '0);
  endfunction

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= {1'b1, din};
    else if (shift) sh_q <= {1'b0, sh_q[SH_W-1:1]};
  end

  assign sh        = sh_q;
  assign final_pos = marker_at_end(sh_q);
endmodule

// File: rtl/bsync_uart_tx_ctrl.sv
module bsync_uart_tx_ctrl
  import bsync_uart_tx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic roll,
  input  logic wr_en,
  input  logic final_pos,
  output logic load,
  output logic shift,
  output logic fin,
  output logic frame_on,
  output logic data_on,
  output logic busy
);
  tx_state_e st_q, st_d;

  assign busy     = (st_q != ST_IDLE);
  assign load     = wr_en && !busy;
  assign shift    = roll && (st_q == ST_BITS);
  assign fin      = shift && final_pos;
  assign frame_on = (st_q == ST_START) || (st_q == ST_BITS);
  assign data_on  = (st_q == ST_BITS);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (load) st_d = ST_WAIT;
      ST_WAIT:  if (roll) st_d = ST_START;
      ST_START: if (roll) st_d = ST_BITS;
      ST_BITS:  if (fin)  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/bsync_uart_tx.sv
module bsync_uart_tx
  import bsync_uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_byte,
  input  logic              done_clr,
  output logic              txd,
  output logic              done_flag,
  output logic              bit_roll
);
  logic              roll_ev, load_ev, shift_ev, fin_ev;
  logic              frame_on, data_on, busy, final_pos;
  logic [DATA_W:0]   sh_q;
  logic              flag_q;

  bsync_uart_tx_div #(.DIV(DIV)) u_div (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .roll(roll_ev)
  );

  bsync_uart_tx_shreg #(.DATA_W(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(load_ev), .din(wr_byte),
    .shift(shift_ev), .sh(sh_q), .final_pos(final_pos)
  );

  bsync_uart_tx_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .roll(roll_ev), .wr_en(wr_en),
    .final_pos(final_pos), .load(load_ev), .shift(shift_ev), .fin(fin_ev),
    .frame_on(frame_on), .data_on(data_on), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)        flag_q <= 1'b0;
    else if (fin_ev)   flag_q <= 1'b1;
    else if (done_clr) flag_q <= 1'b0;
  end

  assign txd       = line_level(frame_on, data_on, sh_q[0]);
  assign done_flag = flag_q;
  assign bit_roll  = roll_ev;
endmodule

// File: rtl/bsync_uart_tx_chk.sv
module bsync_uart_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            os_tick,
  input logic            wr_en,
  input logic            done_clr,
  input logic            txd,
  input logic            done_flag,
  input logic            roll_ev,
  input logic            shift_ev,
  input logic            fin_ev,
  input logic            frame_on,
  input logic            data_on,
  input logic            busy,
  input logic [DATA_W:0] sh_q
);
  a_r8_roll_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    roll_ev |-> os_tick);

  a_r3_start_on_roll: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_on) |-> $past(roll_ev));

  a_r1_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_on && !data_on) |-> !txd);

  a_r4_flag_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
    fin_ev |=> (done_flag && txd && !frame_on));

  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_flag && !done_clr) |=> done_flag);

  a_r5_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && busy && !shift_ev) |=> $stable(sh_q));

  a_r7_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_on |-> txd);
endmodule

bind bsync_uart_tx bsync_uart_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .wr_en(wr_en),
  .done_clr(done_clr), .txd(txd), .done_flag(done_flag), .roll_ev(roll_ev),
  .shift_ev(shift_ev), .fin_ev(fin_ev), .frame_on(frame_on),
  .data_on(data_on), .busy(busy), .sh_q(sh_q)
);

// File: tb/bsync_uart_tx_bench.sv
module bsync_uart_tx_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_byte = 8'h00;
  logic       done_clr = 1'b0;
  logic       txd, done_flag, bit_roll;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;
  string scen = "R7";
  int tick_gap = 1;
  int gcnt = 0;

  // reference model state
  int m_cnt = 0;
  int m_phase = 0;        // 0 idle, 1 waiting for rollover, 2 on the line
  bit m_cur = 1'b1;
  bit m_q[$];
  bit m_flag = 1'b0;
  int obs_rolls = 0;
  bit prev_flag = 1'b0;

  always #5 clk = ~clk;

  bsync_uart_tx u_bsync_uart_tx (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .wr_en(wr_en),
    .wr_byte(wr_byte), .done_clr(done_clr), .txd(txd),
    .done_flag(done_flag), .bit_roll(bit_roll)
  );

  // oversampling tick source
  always @(negedge clk) begin
    if (gcnt >= tick_gap - 1) begin os_tick = 1'b1; gcnt = 0; end
    else begin os_tick = 1'b0; gcnt++; end
  end

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_phase = 0; m_cur = 1'b1; m_flag = 1'b0; m_q.delete();
    end else begin
      automatic bit r = os_tick && (m_cnt == 15);
      automatic int pre = m_phase;
      automatic bit fin = 1'b0;
      if (os_tick) m_cnt = (m_cnt + 1) % 16;
      if (r && pre == 1) begin
        m_cur = m_q.pop_front(); m_phase = 2;
      end else if (r && pre == 2) begin
        if (m_q.size() == 0) begin m_phase = 0; m_cur = 1'b1; fin = 1'b1; end
        else m_cur = m_q.pop_front();
      end
      if (wr_en && pre == 0) begin
        m_q.delete();
        m_q.push_back(1'b0);
        for (int i = 0; i < 8; i++) m_q.push_back(wr_byte[i]);
        m_phase = 1;
      end
      if (fin) m_flag = 1'b1;
      else if (done_clr) m_flag = 1'b0;
    end
  end

  task automatic check(input string req, input string what, input int got, input int exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d (scenario %s)", req, what, got, exp, scen);
    end
  endtask

  // comparison, away from the rising edge and after the inputs settle
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      automatic bit exp_roll = os_tick && (m_cnt == 15);
      automatic bit exp_txd = (m_phase == 2) ? m_cur : 1'b1;
      string tag;
      tag = (m_phase == 1) ? "R3" : (m_phase == 2) ? "R1" : "R4";
      check(tag, "txd", txd, exp_txd);
      check("R6", "done_flag", done_flag, m_flag);
      check("R8", "bit_roll", bit_roll, exp_roll);
      if (done_flag && !prev_flag)
        check("R4", "rollovers before flag", obs_rolls, 10);
      prev_flag = done_flag;
      if (wr_en && m_phase == 0) obs_rolls = 0;
      else if (bit_roll) obs_rolls++;
    end
  end

  task automatic send(input logic [7:0] b);
    @(negedge clk); wr_en = 1'b1; wr_byte = b;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_flag();
    for (int i = 0; i < 4000 && !done_flag; i++) @(negedge clk);
  endtask

  task automatic clear_flag();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #3;
    check("R7", "txd in reset", txd, 1);
    check("R7", "flag in reset", done_flag, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #3;
    check("R7", "txd after reset", txd, 1);
    check("R7", "flag after reset", done_flag, 0);

    scen = "R1"; tick_gap = 1;
    send(8'hA5); wait_flag(); clear_flag();
    send(8'h00); wait_flag(); clear_flag();
    send(8'hFF); wait_flag(); clear_flag();

    scen = "R2"; tick_gap = 3;
    send(8'h3C); wait_flag(); clear_flag();
    tick_gap = 2;
    send(8'h80); wait_flag(); clear_flag();

    scen = "R5"; tick_gap = 1;
    send(8'h0F);
    repeat (20) @(negedge clk);
    send(8'hF0);
    wait_flag(); clear_flag();
    repeat (200) @(negedge clk);

    scen = "R3";
    for (int d = 0; d < 6; d++) begin
      repeat (d) @(negedge clk);
      send(8'h01 << d); wait_flag(); clear_flag();
    end

    scen = "R6";
    send(8'h5A); wait_flag();
    repeat (50) @(negedge clk);
    clear_flag();
    @(negedge clk); done_clr = 1'b1;
    send(8'h81);
    repeat (400) @(negedge clk);
    done_clr = 1'b0;

    scen = "R9";
    send(8'hC3); wait_flag();
    @(negedge clk); done_clr = 1'b1; wr_en = 1'b1; wr_byte = 8'h96;
    @(negedge clk); done_clr = 1'b0; wr_en = 1'b0;
    wait_flag(); clear_flag();

    scen = "R8"; tick_gap = 2;
    repeat (100) @(negedge clk);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule